// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave that lets an external master read and write a bank of 8-bit registers. It runs on a fast system clock and oversamples the chip select, serial clock and data input through a short synchronizer. Each transaction opens with a one-byte command header: a direction flag, a burst flag and a six-bit register address. One or more data bytes follow. Writes come out as one-cycle strobes that carry an address and a byte. Reads pull a byte from the register bank in the cycle they are requested and shift it out most significant bit first.

The serial timing is clock-idle-high with data captured on rising edges. Output data changes after falling edges. The output driver is released whenever chip select is high. A plain mode input moves read data from the dedicated output pin onto the shared bidirectional data pin, for three-wire buses. One address maps to a fixed identification constant. Reading one other address raises a side-effect strobe that clears an external high-pass filter.

The register strobes are valid-only streams with no ready signal. The serial master cannot be stalled, so the register bank must accept every write strobe in the cycle it appears. It must also answer every read strobe combinationally in that same cycle. No back-pressure exists at either edge.

Top module: `spi_regport`

## Requirements
- R1: While the synchronized chip select is high, both output enables are low and no write, read or filter-clear strobe is issued. Every frame starts over at the header when chip select falls.
- R2: The header is the first byte after chip select falls, sent most significant bit first. Header bit 7 is the direction flag (1 = read, 0 = write), bit 6 is the burst flag, and bits 5..0 are the register address.
- R3: In a write, each completed data byte raises `wr_stb_o` for exactly one cycle. The strobe carries that byte, most significant bit first, and its target address.
- R4: With the burst flag at 1, the address steps by one after every completed data byte and wraps from 0x3F to 0x00. With the flag at 0, every byte uses the header address.
- R5: A data byte cut short by chip select rising, with fewer than 8 bits received, produces no write strobe.
- R6: In a read, `rd_stb_o` pulses once at the first falling clock edge of each data byte with the current address on `rd_addr_o`. The returned byte then appears on the output pin most significant bit first, one bit per falling edge, ready to be sampled on the following rising edge.
- R7: A read of `ID_ADDR` (default 0x0F) returns `ID_VALUE` (default 0x3B), whatever `rd_data_i` holds.
- R8: Each read byte taken from `HPF_ADDR` (default 0x23) raises `hpf_clr_o` for exactly one cycle. A write to that address raises no filter clear.
- R9: With `three_wire_i` at 1, read data is driven only through `sdio_o`/`sdio_oe_o` and `sdo_oe_o` stays low. With it at 0, the reverse holds.
- R10: An output enable is high only during the data phase of a read, never during the header or a write. A single cycle never carries both a write strobe and a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select from the master, low during a transaction |
| sck_i | input | 1 | Serial clock from the master, idles high |
| sdi_i | input | 1 | Serial data in, the input buffer of the shared pin in three-wire mode |
| three_wire_i | input | 1 | Selects three-wire mode (from a control register bit) |
| sdo_o | output | 1 | Serial data out, four-wire pin |
| sdo_oe_o | output | 1 | Drive enable of the four-wire data out pin |
| sdio_o | output | 1 | Read data toward the shared data pin |
| sdio_oe_o | output | 1 | Drive enable of the shared data pin |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_addr_o | output | 6 | Write address, valid with the strobe |
| wr_data_o | output | 8 | Write data, valid with the strobe |
| rd_stb_o | output | 1 | One-cycle read strobe |
| rd_addr_o | output | 6 | Read address, valid with the strobe |
| rd_data_i | input | 8 | Read data from the register bank, sampled with the read strobe |
| hpf_clr_o | output | 1 | One-cycle clear strobe for the high-pass filter |

## Verification
The properties assume that each serial clock level lasts at least the synchronizer depth plus two system clocks. Under that assumption every detected edge is a single-cycle pulse, and the filter clear and the strobes never fall on back-to-back cycles. They also assume that `three_wire_i` changes only while chip select is high, and that chip select does not toggle between two serial clock edges faster than the synchronizer can follow. The stimulus holds each serial clock level for six system clocks and changes data only at falling serial edges. It toggles the mode input only between transactions and leaves an idle gap after every chip select rise.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = DATA_W - 2;
  localparam int CNT_W  = $clog2(DATA_W);

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  bitcnt_t;
endpackage

// File: rtl/spi_sync.sv
// Multi-bit level synchronizer: STAGES flops per bit (STAGES >= 2).
module spi_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  localparam int PIPE_W = N * STAGES;

  logic [PIPE_W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= {pipe_q[PIPE_W-N-1:0], d_i};
  end

  assign q_o = pipe_q[PIPE_W-1 -: N];
endmodule

// File: rtl/spi_frame.sv
// Header decode, bit counting, input shifting and address stepping.
module spi_frame
  import spi_regport_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  idle_i,
  input  logic  rise_i,
  input  logic  fall_i,
  input  logic  bit_i,
  output logic  wr_stb_o,
  output addr_t wr_addr_o,
  output byte_t wr_data_o,
  output logic  load_o,
  output addr_t addr_o,
  output logic  rw_o
);
  logic                in_hdr_q;
  bitcnt_t             cnt_q;
  logic [DATA_W-2:0]   shreg_q;
  logic                rw_q;
  logic                burst_q;
  addr_t               addr_q;
  byte_t               byte_now;
  logic                byte_done;

  assign byte_now  = {shreg_q, bit_i};
  assign byte_done = rise_i && (cnt_q == bitcnt_t'(DATA_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_hdr_q <= 1'b1;
      cnt_q    <= '0;
      shreg_q  <= '0;
      rw_q     <= 1'b0;
      burst_q  <= 1'b0;
      addr_q   <= '0;
    end else if (idle_i) begin
      in_hdr_q <= 1'b1;
      cnt_q    <= '0;
      rw_q     <= 1'b0;
    end else if (rise_i) begin
      shreg_q <= byte_now[DATA_W-2:0];
      cnt_q   <= byte_done ? '0 : cnt_q + 1'b1;
      if (byte_done) begin
        if (in_hdr_q) begin
          rw_q     <= byte_now[DATA_W-1];
          burst_q  <= byte_now[DATA_W-2];
          addr_q   <= byte_now[ADDR_W-1:0];
          in_hdr_q <= 1'b0;
        end else if (burst_q) begin
          addr_q <= addr_q + 1'b1;
        end
      end
    end
  end

  assign wr_stb_o  = byte_done && !in_hdr_q && !rw_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = byte_now;
  assign load_o    = fall_i && !in_hdr_q && rw_q && (cnt_q == '0);
  assign addr_o    = addr_q;
  assign rw_o      = rw_q;

  // R1: no register traffic while deselected
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |-> (!wr_stb_o && !load_o));

  // R4: burst steps the address after a data byte
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !in_hdr_q && burst_q && !idle_i) |=> (addr_q == $past(addr_q) + 1'b1));

  // R4: fixed mode never moves the address during the data phase
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !in_hdr_q && !burst_q && !idle_i) |=> $stable(addr_q));
endmodule

// File: rtl/spi_tx.sv
// Read data shifter and drive-enable state.
module spi_tx
  import spi_regport_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  idle_i,
  input  logic  load_i,
  input  logic  fall_i,
  input  byte_t data_i,
  output logic  bit_o,
  output logic  active_o
);
  byte_t txreg_q;
  logic  active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txreg_q  <= '0;
      active_q <= 1'b0;
    end else if (idle_i) begin
      txreg_q  <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      txreg_q  <= data_i;
      active_q <= 1'b1;
    end else if (fall_i && active_q) begin
      txreg_q <= {txreg_q[DATA_W-2:0], 1'b0};
    end
  end

  assign bit_o    = txreg_q[DATA_W-1];
  assign active_o = active_q;

  // R1: driver released one cycle after deselect is seen
  p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |=> !active_o);
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int    SYNC_STAGES = 2,
  parameter addr_t ID_ADDR     = 6'h0F,
  parameter byte_t ID_VALUE    = 8'h3B,
  parameter addr_t HPF_ADDR    = 6'h23
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_n_i,
  input  logic  sck_i,
  input  logic  sdi_i,
  input  logic  three_wire_i,
  output logic  sdo_o,
  output logic  sdo_oe_o,
  output logic  sdio_o,
  output logic  sdio_oe_o,
  output logic  wr_stb_o,
  output addr_t wr_addr_o,
  output byte_t wr_data_o,
  output logic  rd_stb_o,
  output addr_t rd_addr_o,
  input  byte_t rd_data_i,
  output logic  hpf_clr_o
);
  logic  cs_s, sck_s, sdi_s, sck_d;
  logic  rise, fall;
  logic  load, rw, tx_bit, active;
  addr_t cur_addr;
  byte_t rd_val;

  spi_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({cs_n_i, sck_i, sdi_i}),
    .q_o  ({cs_s, sck_s, sdi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b1;
    else        sck_d <= sck_s;
  end

  assign rise = !cs_s && sck_s && !sck_d;
  assign fall = !cs_s && !sck_s && sck_d;

  spi_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .idle_i   (cs_s),
    .rise_i   (rise),
    .fall_i   (fall),
    .bit_i    (sdi_s),
    .wr_stb_o (wr_stb_o),
    .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o),
    .load_o   (load),
    .addr_o   (cur_addr),
    .rw_o     (rw)
  );

  assign rd_stb_o  = load;
  assign rd_addr_o = cur_addr;
  assign rd_val    = (cur_addr == ID_ADDR) ? ID_VALUE : rd_data_i;
  assign hpf_clr_o = load && (cur_addr == HPF_ADDR);

  spi_tx u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle_i  (cs_s),
    .load_i  (load),
    .fall_i  (fall),
    .data_i  (rd_val),
    .bit_o   (tx_bit),
    .active_o(active)
  );

  assign sdo_o     = tx_bit;
  assign sdio_o    = tx_bit;
  assign sdo_oe_o  = active && !three_wire_i;
  assign sdio_oe_o = active && three_wire_i;

  // R10: a strobe cycle is either a write or a read
  p_wr_rd_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb_o && rd_stb_o));

  // R10: driving only in a read frame
  p_oe_read_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_o || sdio_oe_o) |-> rw);

  // R8: filter clear lasts a single cycle
  p_hpf_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hpf_clr_o |=> !hpf_clr_o);

  // R1: deselected port issues no filter clear
  p_hpf_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |-> !hpf_clr_o);
endmodule

// File: tb/spi_regport_tb.sv
module spi_regport_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sck = 1'b1, sdi = 1'b0, three_wire = 1'b0;
  logic       sdo, sdo_oe, sdio, sdio_oe;
  logic       wr_stb, rd_stb, hpf_clr;
  logic [5:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  int vectors = 0;
  int fails   = 0;
  int nwr = 0, nrd = 0, nhpf = 0;
  logic [5:0] wr_a [0:7];
  logic [7:0] wr_d [0:7];
  logic [7:0] tx_bytes [0:3];
  logic [7:0] rx_bytes [0:3];
  logic       oe_hdr, oe4, oe3;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bank_val(input logic [5:0] a);
    return {a, 2'b01} ^ 8'h5A;
  endfunction

  always_comb rd_data = bank_val(rd_addr);

  spi_regport u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .sdi_i(sdi),
    .three_wire_i(three_wire), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .sdio_o(sdio), .sdio_oe_o(sdio_oe), .wr_stb_o(wr_stb),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .rd_stb_o(rd_stb),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data), .hpf_clr_o(hpf_clr)
  );

  always @(posedge clk) begin
    if (wr_stb) begin
      if (nwr < 8) begin
        wr_a[nwr] <= wr_addr;
        wr_d[nwr] <= wr_data;
      end
      nwr <= nwr + 1;
    end
    if (rd_stb)  nrd  <= nrd + 1;
    if (hpf_clr) nhpf <= nhpf + 1;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    @(negedge clk);
    nwr = 0; nrd = 0; nhpf = 0;
    oe_hdr = 1'b0; oe4 = 1'b0; oe3 = 1'b0;
  endtask

  // nbytes full bytes, then part_bits bits of tx_bytes[nbytes]
  task automatic xfer(input int nbytes, input int part_bits);
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbytes + 1; b++) begin
      for (int i = 7; i >= 0; i--) begin
        if (b == nbytes && (7 - i) >= part_bits) break;
        sck = 1'b0;
        sdi = tx_bytes[b][i];
        repeat (HALF) @(negedge clk);
        if (b == 0) oe_hdr = oe_hdr | sdo_oe | sdio_oe;
        else begin
          oe4 = oe4 | sdo_oe;
          oe3 = oe3 | sdio_oe;
        end
        if (b < 4) rx_bytes[b][i] = three_wire ? sdio : sdo;
        sck = 1'b1;
        repeat (HALF) @(negedge clk);
      end
    end
    cs_n = 1'b1;
    repeat (HALF + 4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!sdo_oe && !sdio_oe, "R1 reset oe", {sdo_oe, sdio_oe}, 0);
    chk(!wr_stb && !rd_stb && !hpf_clr, "R1 reset strobes", {wr_stb, rd_stb, hpf_clr}, 0);
  endtask

  task automatic t_write_single();
    clear_logs();
    tx_bytes[0] = 8'h10; tx_bytes[1] = 8'h5C;
    xfer(2, 0);
    chk(nwr == 1, "R3 write count", nwr, 1);
    chk(wr_a[0] == 6'h10 && wr_d[0] == 8'h5C, "R2 R3 write addr/data", {wr_a[0], wr_d[0]}, {6'h10, 8'h5C});
    chk(!oe_hdr && !oe4 && !oe3, "R10 no drive in write", {oe_hdr, oe4, oe3}, 0);
    chk(nrd == 0, "R10 no read strobe in write", nrd, 0);
  endtask

  task automatic t_write_burst();
    clear_logs();
    tx_bytes[0] = 8'h60; tx_bytes[1] = 8'hA1; tx_bytes[2] = 8'hB2; tx_bytes[3] = 8'hC3;
    xfer(4, 0);
    chk(nwr == 3, "R3 burst write count", nwr, 3);
    chk(wr_a[0] == 6'h20 && wr_a[1] == 6'h21 && wr_a[2] == 6'h22, "R4 burst addresses",
        {wr_a[0], wr_a[1], wr_a[2]}, {6'h20, 6'h21, 6'h22});
    chk(wr_d[0] == 8'hA1 && wr_d[1] == 8'hB2 && wr_d[2] == 8'hC3, "R3 burst data",
        {wr_d[0], wr_d[1], wr_d[2]}, 24'hA1B2C3);
  endtask

  task automatic t_write_fixed();
    clear_logs();
    tx_bytes[0] = 8'h2A; tx_bytes[1] = 8'h11; tx_bytes[2] = 8'h22;
    xfer(3, 0);
    chk(nwr == 2, "R3 fixed write count", nwr, 2);
    chk(wr_a[0] == 6'h2A && wr_a[1] == 6'h2A, "R4 fixed address", {wr_a[0], wr_a[1]}, {6'h2A, 6'h2A});
    chk(wr_d[1] == 8'h22, "R3 second byte", wr_d[1], 8'h22);
  endtask

  task automatic t_read_single();
    clear_logs();
    tx_bytes[0] = 8'h85; tx_bytes[1] = 8'h00;
    xfer(2, 0);
    chk(rx_bytes[1] == bank_val(6'h05), "R6 read data", rx_bytes[1], bank_val(6'h05));
    chk(nrd == 1 && nwr == 0, "R6 R10 strobe counts", {nrd[7:0], nwr[7:0]}, 16'h0100);
    chk(!oe_hdr && oe4 && !oe3, "R10 R9 drive window", {oe_hdr, oe4, oe3}, 3'b010);
    chk(!sdo_oe && !sdio_oe, "R1 released after read", {sdo_oe, sdio_oe}, 0);
  endtask

  task automatic t_read_wrap();
    clear_logs();
    tx_bytes[0] = 8'hFE; tx_bytes[1] = 0; tx_bytes[2] = 0; tx_bytes[3] = 0;
    xfer(4, 0);
    chk(rx_bytes[1] == bank_val(6'h3E), "R4 burst read 0", rx_bytes[1], bank_val(6'h3E));
    chk(rx_bytes[2] == bank_val(6'h3F), "R4 burst read 1", rx_bytes[2], bank_val(6'h3F));
    chk(rx_bytes[3] == bank_val(6'h00), "R4 burst read wrap", rx_bytes[3], bank_val(6'h00));
    chk(nrd == 3, "R6 one read strobe per byte", nrd, 3);
  endtask

  task automatic t_read_id();
    clear_logs();
    tx_bytes[0] = 8'h8F; tx_bytes[1] = 8'h00;
    xfer(2, 0);
    chk(rx_bytes[1] == 8'h3B, "R7 identification value", rx_bytes[1], 8'h3B);
  endtask

  task automatic t_hpf();
    clear_logs();
    tx_bytes[0] = 8'hA3; tx_bytes[1] = 8'h00;
    xfer(2, 0);
    chk(nhpf == 1, "R8 filter clear on read", nhpf, 1);
    clear_logs();
    tx_bytes[0] = 8'h23; tx_bytes[1] = 8'h77;
    xfer(2, 0);
    chk(nhpf == 0, "R8 no clear on write", nhpf, 0);
    chk(nwr == 1 && wr_a[0] == 6'h23, "R3 write to filter address", {nwr[7:0], 2'b00, wr_a[0]}, 16'h0123);
  endtask

  task automatic t_partial();
    clear_logs();
    tx_bytes[0] = 8'h30; tx_bytes[1] = 8'hFF;
    xfer(1, 5);
    chk(nwr == 0, "R5 partial byte dropped", nwr, 0);
    clear_logs();
    tx_bytes[0] = 8'h31; tx_bytes[1] = 8'h9E;
    xfer(2, 0);
    chk(nwr == 1 && wr_a[0] == 6'h31 && wr_d[0] == 8'h9E, "R1 fresh header after partial",
        {wr_a[0], wr_d[0]}, {6'h31, 8'h9E});
  endtask

  task automatic t_three_wire();
    @(negedge clk) three_wire = 1'b1;
    clear_logs();
    tx_bytes[0] = 8'h85; tx_bytes[1] = 8'h00;
    xfer(2, 0);
    chk(rx_bytes[1] == bank_val(6'h05), "R9 shared pin data", rx_bytes[1], bank_val(6'h05));
    chk(oe3 && !oe4 && !oe_hdr, "R9 shared pin enable", {oe_hdr, oe4, oe3}, 3'b001);
    @(negedge clk) three_wire = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_single();
    t_write_burst();
    t_write_fixed();
    t_read_single();
    t_read_wrap();
    t_read_id();
    t_hpf();
    t_partial();
    t_three_wire();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule